// File: doc/BRIEF.md
# Programmable Gated Clock Divider

This block conditions one already-selected source clock. It divides the source by a ratio taken from a small control word and then passes the result through a glitch-free clock gate. It also stores the parent-select state for a source mux outside the block and presents it as a four-bit parent index. The mux itself is not part of the block.

The divide ratio is decoded in priority order:
- A divide-by-3 override wins over every other divide bit.
- Otherwise a divide-enable bit chooses between a straight pass-through and a non-linear ratio table.

A new ratio is adopted only at the end of the output period in progress. The output therefore never shows a shortened pulse. Every ratio gives a 50% duty output. The odd ratio 3 gets this by combining a rising-edge register with a falling-edge register.

Software-side logic uses two ports:
- A whole-word write port, with a combinational read-back of the word.
- A parent-index write port that updates only the source fields.

Top module: `clkdiv_gate_unit`

## Requirements
- R1: When control bit 2 (divide-by-3 override) is 1, the output period is 3 source periods, whatever bits 1 and 5:3 hold.
- R2: When bits 2 and 1 are both 0, the output period equals the source period.
- R3: When bit 2 is 0 and bit 1 is 1, bits 5:3 select the ratio: code 0→1, 1→2, 2→4, 3→6, 4→8, 5→12, 6→1, 7→1.
- R4: Bit 0 is the gate. When it is 1 the output toggles. When it is 0 the output stays low. Its current value reads back at rd_data[0].
- R5: parent_idx is 0 when bit 6 (source switch) is 0. It is 1 + bits 9:7 (source select) when bit 6 is 1.
- R6: A parent write of index 0 clears only bit 6 and leaves bits 9:7 unchanged. A parent write of index k in 1..8 sets bit 6 and stores k-1 in bits 9:7. When both write ports are active in the same cycle, the parent write takes priority for bits 9:6.
- R7: A ratio change takes effect only at the start of a new output period. No high or low output phase is ever shorter than half a source period.
- R8: For every ratio, the high time of the output is exactly half its period. This includes ratio 3, whose high time is 1.5 source periods.
- R9: After a synchronous reset, the control word reads 0, parent_idx is 0 and the output stays low.
- R10: A word write (wr_en) stores wr_data into the control word in the next cycle. rd_data returns the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to divide |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write the whole control word |
| wr_data | input | 10 | Control word to write |
| par_wr_en | input | 1 | Write the parent index |
| par_wr_idx | input | 4 | Parent index to write (0..8) |
| rd_data | output | 10 | Current control word |
| parent_idx | output | 4 | Decoded parent index for the external mux |
| clk_out | output | 1 | Divided, gated clock |

## Verification
The divider is tried with three kinds of input:
- Directed words that set the override together with conflicting divide bits. These separate the override priority from the table path.
- Directed words for every table code, including the two codes that fall back to ratio 1. These expose a misordered or off-by-one table.
- Random words with a fixed seed. These mix switch states so that changes between very different ratios, such as 12 to 1, are crossed.

Throughout the run, the bench tracks the shortest high and low phases, which exposes a ratio change applied in the middle of a period. Parent-index writes of 0 after a nonzero index separate "clear the switch only" from "clear both fields".

// File: rtl/clkdiv_pkg.sv
// Shared types and helpers for the gated clock divider.
// Assumes the control word layout listed in the brief (gate at bit 0).
package clkdiv_pkg;
    localparam int SEL_W  = 3;              // width of select fields
    localparam int RAT_W  = 4;              // wide enough for ratio 12
    localparam int IDX_W  = SEL_W + 1;      // parent index 0..2**SEL_W
    localparam int CTRL_W = 2 * SEL_W + 4;  // whole control word

    // Packed control word: first member is the MSB.
    typedef struct packed {
        logic [SEL_W-1:0] src_sel;   // bits 9:7
        logic             src_sw;    // bit 6
        logic [SEL_W-1:0] div_sel;   // bits 5:3
        logic             div3_sw;   // bit 2
        logic             div_sw;    // bit 1
        logic             gate;      // bit 0
    } ctrl_t;

    // Decode the requested divide ratio with override priority.
    function automatic logic [RAT_W-1:0] ratio_of(input ctrl_t c);
        logic [RAT_W-1:0] r;
        if (c.div3_sw)      r = RAT_W'(3);
        else if (!c.div_sw) r = RAT_W'(1);
        else begin
            case (c.div_sel)
                3'd1:    r = RAT_W'(2);
                3'd2:    r = RAT_W'(4);
                3'd3:    r = RAT_W'(6);
                3'd4:    r = RAT_W'(8);
                3'd5:    r = RAT_W'(12);
                default: r = RAT_W'(1);
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/clkdiv_ctrl_regs.sv
// Control word storage with whole-word and parent-index write paths.
// Assumes both writes are synchronous to clk; the parent write wins bits 9:6.
module clkdiv_ctrl_regs
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  ctrl_t            wr_data,
    input  logic             par_wr_en,
    input  logic [IDX_W-1:0] par_wr_idx,
    output ctrl_t            ctrl_q
);
    // Update the control word from either write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en) ctrl_q <= wr_data;
            if (par_wr_en) begin
                if (par_wr_idx == '0) begin
                    ctrl_q.src_sw <= 1'b0;
                end else begin
                    ctrl_q.src_sw  <= 1'b1;
                    ctrl_q.src_sel <= SEL_W'(par_wr_idx - 1'b1);
                end
            end
        end
    end

    // R6
    par_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_wr_en && par_wr_idx == '0 |=> !ctrl_q.src_sw);
    // R6
    par_keep_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_wr_en && par_wr_idx == '0 && !wr_en |=> $stable(ctrl_q.src_sel));
    // R6
    par_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_wr_en && par_wr_idx != '0 |=>
            ctrl_q.src_sw && ctrl_q.src_sel == SEL_W'($past(par_wr_idx) - 1'b1));
endmodule

// File: rtl/clkdiv_ratio_div.sv
// Integer clock divider with 50% duty for ratios 1, 3 and even values.
// Assumes ratio_req is never 0. A new ratio is latched only when the
// current output period wraps.
module clkdiv_ratio_div
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAT_W-1:0] ratio_req,
    output logic             div_clk
);
    logic [RAT_W-1:0] act, cnt, act_nxt, cnt_nxt;
    logic             pos_q, neg_q, pos_nxt, wrap;

    // Next-state of the period counter and the ratio in effect.
    always_comb begin
        wrap    = (cnt == act - 1'b1);
        act_nxt = wrap ? ratio_req : act;
        cnt_nxt = wrap ? '0 : cnt + 1'b1;
        pos_nxt = (cnt_nxt < (act_nxt >> 1));
    end

    // Rising-edge state: counter, active ratio, high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= RAT_W'(1);
            cnt   <= '0;
            pos_q <= 1'b0;
        end else begin
            act   <= act_nxt;
            cnt   <= cnt_nxt;
            pos_q <= pos_nxt;
        end
    end

    // Falling-edge copy that stretches the ratio-3 high phase by half a cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= pos_q;
    end

    // Pick the output form for the ratio in effect.
    always_comb begin
        if (act == RAT_W'(1))      div_clk = clk;
        else if (act == RAT_W'(3)) div_clk = pos_q | neg_q;
        else                       div_clk = pos_q;
    end

    // R7
    ratio_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act != $past(act) |-> cnt == '0);
    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < act);
    // R8
    high_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pos_q) |-> cnt == '0);
    // R3
    legal_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == 1 || act == 2 || act == 3 || act == 4 ||
        act == 6 || act == 8 || act == 12);
endmodule

// File: rtl/clkdiv_gate_cell.sv
// Latch-based clock gate: enable passes only while the gated clock is low,
// so a high phase already under way is never cut short.
module clkdiv_gate_cell (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);
    logic en_l;

    // Capture the enable while the clock is low.
    always_latch begin
        if (!clk_in) en_l = en;
    end

    assign clk_out = clk_in & en_l;
endmodule

// File: rtl/clkdiv_gate_unit.sv
// Top: control word, ratio divider and output gate.
// Assumes rst_n is synchronous to clk_src and held for at least two edges.
module clkdiv_gate_unit
    import clkdiv_pkg::*;
(
    input  logic              clk_src,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              par_wr_en,
    input  logic [IDX_W-1:0]  par_wr_idx,
    output logic [CTRL_W-1:0] rd_data,
    output logic [IDX_W-1:0]  parent_idx,
    output logic              clk_out
);
    ctrl_t ctrl_q;
    logic  div_clk;

    clkdiv_ctrl_regs u_regs (
        .clk        (clk_src),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (ctrl_t'(wr_data)),
        .par_wr_en  (par_wr_en),
        .par_wr_idx (par_wr_idx),
        .ctrl_q     (ctrl_q)
    );

    clkdiv_ratio_div u_div (
        .clk       (clk_src),
        .rst_n     (rst_n),
        .ratio_req (ratio_of(ctrl_q)),
        .div_clk   (div_clk)
    );

    clkdiv_gate_cell u_gate (
        .clk_in  (div_clk),
        .en      (ctrl_q.gate),
        .clk_out (clk_out)
    );

    // Present the stored word and the decoded parent index.
    always_comb begin
        rd_data    = ctrl_q;
        parent_idx = ctrl_q.src_sw ? IDX_W'(ctrl_q.src_sel) + 1'b1 : '0;
    end

    // R5
    parent_zero_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        $fell(rd_data[6]) |-> parent_idx == '0);
    // R9
    reset_clear_chk: assert property (@(posedge clk_src)
        !$past(rst_n) && rst_n |-> rd_data == '0);
endmodule

// File: tb/clkdiv_gate_unit_test.sv
`timescale 1ns/1ps
module clkdiv_gate_unit_test;
    logic       clk_src = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic       par_wr_en = 1'b0;
    logic [3:0] par_wr_idx = '0;
    logic [9:0] rd_data;
    logic [3:0] parent_idx;
    logic       clk_out;

    int checks = 0;
    int errors = 0;

    clkdiv_gate_unit uut (
        .clk_src(clk_src), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .par_wr_en(par_wr_en), .par_wr_idx(par_wr_idx), .rd_data(rd_data),
        .parent_idx(parent_idx), .clk_out(clk_out)
    );

    always #5 clk_src = ~clk_src;

    // Edge monitor for period, high time, minimum phases and rise count
    bit  mon_on = 1'b0;
    bit  seen_rise = 1'b0;
    time t_rise = 0, t_fall = 0;
    int  per_ns = 0, hi_ns = 0, rises = 0;
    int  min_hi = 1000, min_lo = 1000;

    always @(posedge clk_out) if (mon_on) begin
        if (seen_rise) begin
            per_ns = int'($time - t_rise);
            if (int'($time - t_fall) < min_lo) min_lo = int'($time - t_fall);
        end
        t_rise = $time; seen_rise = 1'b1; rises++;
    end
    always @(negedge clk_out) if (mon_on && seen_rise) begin
        hi_ns = int'($time - t_rise);
        if (hi_ns < min_hi) min_hi = hi_ns;
        t_fall = $time;
    end

    function automatic int exp_ratio(input logic [9:0] w);
        int tbl[8] = '{1, 2, 4, 6, 8, 12, 1, 1};
        if (w[2]) return 3;
        if (!w[1]) return 1;
        return tbl[w[5:3]];
    endfunction

    function automatic int exp_parent(input logic [9:0] w);
        return w[6] ? int'(w[9:7]) + 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk_src);
    endtask

    task automatic write_word(input logic [9:0] w);
        @(negedge clk_src); wr_en = 1'b1; wr_data = w;
        @(negedge clk_src); wr_en = 1'b0;
    endtask

    task automatic write_par(input logic [3:0] k);
        @(negedge clk_src); par_wr_en = 1'b1; par_wr_idx = k;
        @(negedge clk_src); par_wr_en = 1'b0;
    endtask

    // Apply a word, let the ratio settle, compare period and high time
    task automatic try_ratio(input string req, input logic [9:0] w);
        int r;
        r = exp_ratio(w);
        write_word(w);
        check("R10", int'(rd_data), int'(w));
        cycles(60);
        check(req, per_ns, r * 10);
        check("R8", hi_ns, r * 5);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [9:0] w;
        void'($urandom(32'd2024));
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        mon_on = 1'b1;
        // R9 reset state
        check("R9", int'(rd_data), 0);
        check("R9", int'(parent_idx), 0);
        cycles(20);
        check("R9", rises, 0);

        // R2 pass-through with gate on
        try_ratio("R2", 10'b000_0_000_0_0_1);
        // R3 every table code
        for (int c = 0; c < 8; c++)
            try_ratio("R3", {4'b0, 3'(c), 1'b0, 1'b1, 1'b1});
        // R1 override beats conflicting divide bits
        try_ratio("R1", 10'b000_0_101_1_1_1);
        try_ratio("R1", 10'b000_0_011_1_0_1);

        // R4 gate off holds low, then on again
        write_word(10'b000_0_100_0_1_0);
        check("R4", int'(rd_data[0]), 0);
        cycles(30);
        rises = 0;
        cycles(60);
        check("R4", rises, 0);
        write_word(10'b000_0_100_0_1_1);
        check("R4", int'(rd_data[0]), 1);
        cycles(60);
        check("R4", (rises > 0) ? 1 : 0, 1);

        // R5/R6 parent index writes
        write_par(4'd5);
        check("R6", int'(rd_data[9:6]), 4'b100_1);
        check("R5", int'(parent_idx), 5);
        write_par(4'd0);
        check("R6", int'(rd_data[9:6]), 4'b100_0);
        check("R5", int'(parent_idx), 0);
        write_par(4'd8);
        check("R5", int'(parent_idx), 8);
        write_par(4'd1);
        check("R5", int'(parent_idx), 1);
        // R6 parent write wins over word write for source bits
        @(negedge clk_src);
        wr_en = 1'b1; wr_data = 10'b111_0_000_0_0_1;
        par_wr_en = 1'b1; par_wr_idx = 4'd3;
        @(negedge clk_src);
        wr_en = 1'b0; par_wr_en = 1'b0;
        check("R6", int'(rd_data[9:6]), 4'b010_1);

        // Random words with gate on
        for (int i = 0; i < 24; i++) begin
            w = 10'($urandom) | 10'd1;
            try_ratio("R3", w);
            check("R5", int'(parent_idx), exp_parent(w));
        end

        // R7 no runt phase across all ratio changes
        check("R7", (min_hi >= 5) ? 1 : 0, 1);
        check("R7", (min_lo >= 5) ? 1 : 0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule